// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one output-compare channel of a timer. An external counter value is compared every clock with the channel's active compare value. A 3-bit mode field then shapes a registered reference waveform. The reference can be held, set or cleared on a match, toggled on a match, forced to a fixed level, or run as one of two pulse-width modes that take the count direction into account. The reference is active-high. Two polarity bits turn it into a main output and a complementary output. No dead time is inserted between them.

Software reaches the channel through a one-bit-address write port. Address 0 holds the compare value. Address 1 holds the control word: mode, preload enable, the two polarity bits, an output-select bit and a two-bit lock level. With preload enabled, compare writes land in a shadow copy. That copy moves to the active compare value on an update-event strobe. A lock level of 3 on a channel selected as output freezes the mode and preload-enable bits.

Top module: `occ_channel`

## Requirements
- R1: After reset the reference is low, the mode is frozen, preload is disabled and the active compare value is zero. With both polarity bits 0, the main output is 0 and the complementary output is 1.
- R2: In mode 000 (frozen) the reference holds its value, whether or not the counter equals the compare value.
- R3: Mode 001 drives the reference high on a clock where the counter equals the compare value. Mode 010 drives it low on such a clock. On other clocks both modes hold the reference.
- R4: Mode 011 inverts the reference on every clock where the counter equals the compare value, and holds it otherwise.
- R5: Mode 100 holds the reference low and mode 101 holds it high, whatever the comparison.
- R6: Mode 110: counting up (down flag 0), the reference is high while counter < compare and low otherwise. Counting down (down flag 1), it is low while counter > compare and high otherwise.
- R7: Mode 111 gives the inverse levels of mode 110 in both count directions.
- R8: In modes 110 and 111 the reference changes only when the comparison outcome changes from one clock to the next, or on the first clock after the mode was frozen. Entering a pulse-width mode from any other mode keeps the reference until the outcome changes.
- R9: With preload disabled, a compare write is active from the next clock. With preload enabled, a compare write goes to the shadow copy only. An update-event strobe copies the shadow into the active value at that edge, and a match against the new value can occur from the following clock.
- R10: The main output is the reference XOR the main polarity bit. The complementary output is the inverted reference XOR the complementary polarity bit.
- R11: While the lock level is 3 and the output-select bit is 1, control writes leave the mode and preload-enable bits unchanged. The polarity bits and the output-select bit stay writable. The lock field can be written only while the lock level is 0.
- R12: Control word bit positions: [2:0] mode, [3] preload enable, [4] main polarity, [5] complementary polarity, [6] output select, [8:7] lock level. The compare value sits in the low bits of the write data.
- R13: The reference is a register. It reflects the counter, direction and mode present at a clock edge, and is visible after that edge. A control write therefore affects the reference from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | External counter value |
| cnt_down_i | input | 1 | Count direction, 1 = counting down |
| upd_evt_i | input | 1 | Update-event strobe, one clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = compare value, 1 = control word |
| wr_data_i | input | max(CNT_W,9) | Write data |
| oc_ref_o | output | 1 | Reference waveform, active high |
| oc_main_o | output | 1 | Main output after polarity |
| oc_comp_o | output | 1 | Complementary output after polarity |

## Verification
A counter value driven before a rising edge shows up on the reference, and on both outputs, just after that edge. A register write lands at its own edge and shapes the reference only from the next edge. A preloaded compare value becomes usable one edge after the update strobe that moves it. The bench drives every input on the falling edge and samples 1 ns after the rising edge that is due to show the result. It sweeps every compare value against every counter value in both pulse-width modes and both directions on a 4-bit counter. It computes the expected level arithmetically.

// File: rtl/occ_pkg.sv
package occ_pkg;

    typedef enum logic [2:0] {
        OCM_FROZEN = 3'b000,
        OCM_SET    = 3'b001,
        OCM_CLR    = 3'b010,
        OCM_TOG    = 3'b011,
        OCM_LOW    = 3'b100,
        OCM_HIGH   = 3'b101,
        OCM_PWM_A  = 3'b110,
        OCM_PWM_B  = 3'b111
    } ocm_e;

    // control word layout
    localparam int CF_MODE_LSB = 0;
    localparam int CF_PE       = 3;
    localparam int CF_POL_MAIN = 4;
    localparam int CF_POL_COMP = 5;
    localparam int CF_OUTSEL   = 6;
    localparam int CF_LOCK_LSB = 7;
    localparam int CTRL_W      = 9;

    localparam logic       ADDR_CMP  = 1'b0;
    localparam logic       ADDR_CTRL = 1'b1;
    localparam logic [1:0] LOCK_MAX  = 2'd3;

endpackage

// File: rtl/occ_cfg_regs.sv
module occ_cfg_regs
    import occ_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WR_W  = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [WR_W-1:0]  wr_data_i,
    input  logic             upd_evt_i,
    output ocm_e             mode_o,
    output logic             pol_main_o,
    output logic             pol_comp_o,
    output logic [CNT_W-1:0] cmp_act_o
);

    typedef struct packed {
        ocm_e             mode;
        logic             pe;
        logic             pol_main;
        logic             pol_comp;
        logic             outsel;
        logic [1:0]       lock;
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic protect;

    always_comb begin
        cfg_d   = cfg_q;
        protect = (cfg_q.lock == LOCK_MAX) && cfg_q.outsel;

        if (wr_en_i && (wr_addr_i == ADDR_CTRL)) begin
            if (!protect) begin
                cfg_d.mode = ocm_e'(wr_data_i[CF_MODE_LSB +: 3]);
                cfg_d.pe   = wr_data_i[CF_PE];
            end
            cfg_d.pol_main = wr_data_i[CF_POL_MAIN];
            cfg_d.pol_comp = wr_data_i[CF_POL_COMP];
            cfg_d.outsel   = wr_data_i[CF_OUTSEL];
            if (cfg_q.lock == 2'd0) begin
                cfg_d.lock = wr_data_i[CF_LOCK_LSB +: 2];
            end
        end

        if (wr_en_i && (wr_addr_i == ADDR_CMP)) begin
            cfg_d.shadow = wr_data_i[CNT_W-1:0];
            if (!cfg_q.pe) begin
                cfg_d.active = wr_data_i[CNT_W-1:0];
            end
        end

        if (cfg_q.pe && upd_evt_i) begin
            cfg_d.active = cfg_q.shadow;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '{mode: OCM_FROZEN, default: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_o     = cfg_q.mode;
    assign pol_main_o = cfg_q.pol_main;
    assign pol_comp_o = cfg_q.pol_comp;
    assign cmp_act_o  = cfg_q.active;

    // R11: protected mode field is not altered by a control write
    a_r11_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cfg_q.lock == LOCK_MAX) && cfg_q.outsel && wr_en_i && (wr_addr_i == ADDR_CTRL))
        |=> $stable(cfg_q.mode));

    // R11: a non-zero lock level never changes
    a_r11_lock_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q.lock != 2'd0) |=> $stable(cfg_q.lock));

    // R9: with preload on, the active value moves only on an update event
    a_r9_preload_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q.pe && !upd_evt_i) |=> $stable(cfg_q.active));

endmodule

// File: rtl/occ_ref_gen.sv
module occ_ref_gen
    import occ_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  ocm_e             mode_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             ref_o
);

    typedef struct packed {
        logic ref_lvl;
        logic raw;
        logic was_frozen;
    } st_t;

    st_t  st_d, st_q;
    logic match;
    logic raw_now;

    always_comb begin
        st_d    = st_q;
        match   = (cnt_i == cmp_i);
        // level of the first pulse-width mode for this direction
        raw_now = cnt_down_i ? !(cnt_i > cmp_i) : (cnt_i < cmp_i);

        st_d.raw        = raw_now;
        st_d.was_frozen = (mode_i == OCM_FROZEN);

        unique case (mode_i)
            OCM_FROZEN: ;
            OCM_SET:    if (match) st_d.ref_lvl = 1'b1;
            OCM_CLR:    if (match) st_d.ref_lvl = 1'b0;
            OCM_TOG:    if (match) st_d.ref_lvl = ~st_q.ref_lvl;
            OCM_LOW:    st_d.ref_lvl = 1'b0;
            OCM_HIGH:   st_d.ref_lvl = 1'b1;
            OCM_PWM_A,
            OCM_PWM_B: begin
                if ((raw_now != st_q.raw) || st_q.was_frozen) begin
                    st_d.ref_lvl = raw_now ^ (mode_i == OCM_PWM_B);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_o = st_q.ref_lvl;

    // R2: frozen mode holds the reference
    a_r2_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == OCM_FROZEN) |=> $stable(st_q.ref_lvl));

    // R3: set on match
    a_r3_set_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode_i == OCM_SET) && (cnt_i == cmp_i)) |=> st_q.ref_lvl);

    // R4: toggle on match
    a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode_i == OCM_TOG) && (cnt_i == cmp_i)) |=> (st_q.ref_lvl != $past(st_q.ref_lvl)));

    // R5: forced levels
    a_r5_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == OCM_LOW) |=> !st_q.ref_lvl);
    a_r5_force_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == OCM_HIGH) |=> st_q.ref_lvl);

    // R6: entering up-counting PWM from frozen takes the comparison level
    a_r6_pwm_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode_i == OCM_PWM_A) && st_q.was_frozen && !cnt_down_i)
        |=> (st_q.ref_lvl == $past(cnt_i < cmp_i)));

endmodule

// File: rtl/occ_out_pol.sv
module occ_out_pol (
    input  logic ref_i,
    input  logic pol_main_i,
    input  logic pol_comp_i,
    output logic main_o,
    output logic comp_o
);

    always_comb begin
        main_o = ref_i ^ pol_main_i;
        comp_o = ~ref_i ^ pol_comp_i;
    end

endmodule

// File: rtl/occ_channel.sv
module occ_channel
    import occ_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                                             clk_i,
    input  logic                                             rst_ni,
    input  logic [CNT_W-1:0]                                 cnt_i,
    input  logic                                             cnt_down_i,
    input  logic                                             upd_evt_i,
    input  logic                                             wr_en_i,
    input  logic                                             wr_addr_i,
    input  logic [((CNT_W > CTRL_W) ? CNT_W : CTRL_W)-1:0]   wr_data_i,
    output logic                                             oc_ref_o,
    output logic                                             oc_main_o,
    output logic                                             oc_comp_o
);

    localparam int WR_W = (CNT_W > CTRL_W) ? CNT_W : CTRL_W;

    ocm_e             mode;
    logic             pol_main;
    logic             pol_comp;
    logic [CNT_W-1:0] cmp_act;

    occ_cfg_regs #(
        .CNT_W (CNT_W),
        .WR_W  (WR_W)
    ) i_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .upd_evt_i  (upd_evt_i),
        .mode_o     (mode),
        .pol_main_o (pol_main),
        .pol_comp_o (pol_comp),
        .cmp_act_o  (cmp_act)
    );

    occ_ref_gen #(
        .CNT_W (CNT_W)
    ) i_ref (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (mode),
        .cnt_i      (cnt_i),
        .cnt_down_i (cnt_down_i),
        .cmp_i      (cmp_act),
        .ref_o      (oc_ref_o)
    );

    occ_out_pol i_pol (
        .ref_i      (oc_ref_o),
        .pol_main_i (pol_main),
        .pol_comp_i (pol_comp),
        .main_o     (oc_main_o),
        .comp_o     (oc_comp_o)
    );

    // R10: equal polarity bits give opposite outputs
    a_r10_pair_opposite: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pol_main == pol_comp) |-> (oc_main_o != oc_comp_o));

endmodule

// File: tb/test_occ_channel.sv
module test_occ_channel;

    localparam int CW  = 4;
    localparam int DW  = 9;
    localparam int TOP = (1 << CW) - 1;

    localparam int M_FRZ = 0, M_SET = 1, M_CLR = 2, M_TOG = 3;
    localparam int M_LOW = 4, M_HIGH = 5, M_PWMA = 6, M_PWMB = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic          dn = 1'b0;
    logic          upd = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          oc_ref, oc_main, oc_comp;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    occ_channel #(.CNT_W(CW)) i_occ_channel (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cnt_i      (cnt),
        .cnt_down_i (dn),
        .upd_evt_i  (upd),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .oc_ref_o   (oc_ref),
        .oc_main_o  (oc_main),
        .oc_comp_o  (oc_comp)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ctrl(input int mode, input bit pe, input bit pm,
                                           input bit pc, input bit outs, input int lock);
        logic [2:0] m;
        logic [1:0] l;
        m = mode[2:0];
        l = lock[1:0];
        return {l, outs, pc, pm, pe, m};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; upd = 1'b0; cnt = '0; dn = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic wmode(input int mode);
        wr(1'b1, ctrl(mode, 1'b0, 1'b0, 1'b0, 1'b0, 0));
    endtask

    task automatic step(input int c, input bit d, input bit u);
        @(negedge clk);
        cnt = c[CW-1:0]; dn = d; upd = u;
        @(posedge clk);
        #1;
        upd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R1: reset state
        chk("R1 ref", oc_ref, 1'b0);
        chk("R1 main", oc_main, 1'b0);
        chk("R1 comp", oc_comp, 1'b1);
        wmode(M_SET);
        step(0, 0, 0);
        chk("R1 compare is zero", oc_ref, 1'b1);

        // R5 and R13
        wmode(M_LOW);
        step(0, 0, 0);
        chk("R5 force low", oc_ref, 1'b0);
        wmode(M_HIGH);
        chk("R13 write edge keeps old mode", oc_ref, 1'b0);
        step(0, 0, 0);
        chk("R5 force high", oc_ref, 1'b1);

        // R2 frozen
        wmode(M_FRZ);
        wr(1'b0, 9'd6);
        step(6, 0, 0);
        chk("R2 frozen hold high", oc_ref, 1'b1);
        wmode(M_LOW);
        step(0, 0, 0);
        wmode(M_FRZ);
        step(6, 0, 0);
        chk("R2 frozen hold low", oc_ref, 1'b0);

        // R3 set / clear
        wmode(M_SET);
        step(2, 0, 0);
        chk("R3 set no match", oc_ref, 1'b0);
        step(6, 0, 0);
        chk("R3 set match", oc_ref, 1'b1);
        step(7, 0, 0);
        chk("R3 set holds", oc_ref, 1'b1);
        wmode(M_CLR);
        step(3, 0, 0);
        chk("R3 clear no match", oc_ref, 1'b1);
        step(6, 1, 0);
        chk("R3 clear match", oc_ref, 1'b0);
        step(8, 0, 0);
        chk("R3 clear holds", oc_ref, 1'b0);

        // R4 toggle
        wmode(M_TOG);
        step(6, 0, 0);
        chk("R4 toggle first", oc_ref, 1'b1);
        step(6, 0, 0);
        chk("R4 toggle second", oc_ref, 1'b0);
        step(1, 0, 0);
        chk("R4 no match holds", oc_ref, 1'b0);
        step(6, 0, 0);
        chk("R4 toggle third", oc_ref, 1'b1);

        // R6 / R7 sweep: every compare value, both modes, both directions
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int c = 0; c <= TOP; c++) begin
                    wmode(M_FRZ);
                    wr(1'b0, 9'(c));
                    wmode(m == 0 ? M_PWMA : M_PWMB);
                    for (int i = 0; i <= TOP; i++) begin
                        int  v;
                        bit  lvl;
                        v = (d == 1) ? (TOP - i) : i;
                        if (d == 0) lvl = (v < c);
                        else        lvl = !(v > c);
                        if (m == 1) lvl = !lvl;
                        step(v, d[0], 0);
                        chk(m == 0 ? "R6 pwm sweep" : "R7 pwm sweep", oc_ref, lvl);
                    end
                end
            end
        end

        // R8 change only on outcome change
        wr(1'b0, 9'd8);
        wmode(M_HIGH);
        step(10, 0, 0);
        wmode(M_PWMA);
        step(10, 0, 0);
        chk("R8 entry from non-frozen holds", oc_ref, 1'b1);
        step(11, 0, 0);
        chk("R8 same outcome holds", oc_ref, 1'b1);
        step(3, 0, 0);
        chk("R8 outcome to high", oc_ref, 1'b1);
        step(9, 0, 0);
        chk("R8 outcome to low", oc_ref, 1'b0);
        wmode(M_HIGH);
        step(10, 0, 0);
        wmode(M_FRZ);
        step(10, 0, 0);
        wmode(M_PWMA);
        step(10, 0, 0);
        chk("R8 entry from frozen loads", oc_ref, 1'b0);

        // R9 preload
        wmode(M_LOW);
        step(0, 0, 0);
        wr(1'b0, 9'd3);
        wr(1'b1, ctrl(M_SET, 1'b1, 1'b0, 1'b0, 1'b0, 0));
        wr(1'b0, 9'd9);
        step(9, 0, 0);
        chk("R9 shadow not active", oc_ref, 1'b0);
        step(9, 0, 1);
        chk("R9 update edge uses old value", oc_ref, 1'b0);
        step(9, 0, 0);
        chk("R9 after update", oc_ref, 1'b1);
        wr(1'b1, ctrl(M_LOW, 1'b0, 1'b0, 1'b0, 1'b0, 0));
        step(0, 0, 0);
        wmode(M_SET);
        wr(1'b0, 9'd4);
        step(4, 0, 0);
        chk("R9 immediate without preload", oc_ref, 1'b1);

        // R10 / R12 polarity
        for (int r = 0; r < 2; r++) begin
            for (int p = 0; p < 4; p++) begin
                wr(1'b1, ctrl(r == 1 ? M_HIGH : M_LOW, 1'b0, p[0], p[1], 1'b0, 0));
                step(0, 0, 0);
                chk("R10 R12 main", oc_main, r[0] ^ p[0]);
                chk("R10 R12 comp", oc_comp, ~r[0] ^ p[1]);
            end
        end

        // R11 lock
        do_reset();
        wmode(M_LOW);
        step(0, 0, 0);
        wr(1'b1, ctrl(M_SET, 1'b0, 1'b0, 1'b0, 1'b1, 3));
        step(4, 0, 0);
        wr(1'b1, ctrl(M_HIGH, 1'b1, 1'b1, 1'b0, 1'b1, 0));
        step(2, 0, 0);
        chk("R11 mode write ignored", oc_ref, 1'b0);
        chk("R11 polarity still writable", oc_main, 1'b1);
        wr(1'b0, 9'd5);
        step(5, 0, 0);
        chk("R11 preload write ignored", oc_ref, 1'b1);
        wr(1'b1, ctrl(M_CLR, 1'b0, 1'b0, 1'b0, 1'b0, 0));
        step(5, 0, 0);
        chk("R11 locked while output selected", oc_ref, 1'b1);
        wr(1'b1, ctrl(M_CLR, 1'b0, 1'b0, 1'b0, 1'b0, 0));
        step(5, 0, 0);
        chk("R11 unlocked as non-output", oc_ref, 1'b0);
        wr(1'b1, ctrl(M_SET, 1'b0, 1'b0, 1'b0, 1'b1, 0));
        wr(1'b1, ctrl(M_LOW, 1'b0, 1'b0, 1'b0, 1'b1, 0));
        step(5, 0, 0);
        chk("R11 lock level write-once", oc_ref, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule